// File: doc/BRIEF.md
# SPI Master Receive/Transmit Timing Adjuster

This block sits between the serial pins of an SPI master and its shift engine and trims the I/O timing. The incoming serial data bit can be held back by zero to three core-clock cycles, the outgoing serial data bit can likewise be held back by zero to three cycles, and the point at which the engine captures a received bit can be moved relative to the nominal sampling edge. The capture point can be placed two cycles early, one cycle early, on the nominal edge, or one cycle late.

To place the capture point ahead of the nominal edge, the shift engine supplies a short pipeline of predicted strobes. One tap fires two cycles before the nominal sampling edge, one fires one cycle before it, and one fires on the edge itself. The block picks one of these taps, or a one-cycle-late copy of the nominal tap. The three 2-bit control codes are chosen by software according to the serial clock rate. They are copied into working registers only while no burst is running, so a setting never changes in the middle of a burst.

Top module: `spi_io_timing`

## Requirements
- R1: While reset is asserted, the working settings are input delay 0, output delay 0 and capture code 0, so the data outputs follow their raw inputs in the same cycle. All delay stages clear to 0, so after reset a newly loaded delay of N cycles gives 0 on the output for its first N cycles.
- R2: With working input-delay code N (0..3), `miso_dly` equals the value `miso_raw` had N clock cycles earlier. Code 0 passes `miso_raw` through in the same cycle.
- R3: With working output-delay code N (0..3), `mosi_dly` equals the value `mosi_raw` had N clock cycles earlier. Code 0 passes `mosi_raw` through in the same cycle.
- R4: Capture code 0 makes `cap_strobe` follow `pre_strobe[0]`, the tap that fires two cycles before the nominal edge.
- R5: Capture code 1 makes `cap_strobe` follow `pre_strobe[1]`, the tap that fires one cycle before the nominal edge.
- R6: Capture code 2 makes `cap_strobe` follow `pre_strobe[2]`, the nominal-edge tap.
- R7: Capture code 3 makes `cap_strobe` equal `pre_strobe[2]` as it was one cycle earlier, which is one cycle late.
- R8: While `burst_active` is high, changes on the three code inputs are ignored and the working settings keep their values.
- R9: On every clock edge with `burst_active` low, the three code inputs are loaded. The new settings take effect from the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_active | input | 1 | High while the engine runs a burst; blocks updates to the settings |
| in_dly_code | input | 2 | Requested input (MISO) delay in cycles, 0..3 |
| out_dly_code | input | 2 | Requested output (MOSI) delay in cycles, 0..3 |
| cap_code | input | 2 | Requested capture position: 0 = two cycles early, 1 = one cycle early, 2 = nominal, 3 = one cycle late |
| miso_raw | input | 1 | Serial input bit from the pin |
| mosi_raw | input | 1 | Serial output bit from the shift engine |
| pre_strobe | input | 3 | Predicted strobes: bit 0 = nominal minus 2, bit 1 = nominal minus 1, bit 2 = nominal |
| miso_dly | output | 1 | Delayed serial input bit sent to the engine |
| mosi_dly | output | 1 | Delayed serial output bit sent to the pin |
| cap_strobe | output | 1 | Adjusted capture strobe |

## Verification
Both data lanes are driven with two different 16-bit non-periodic bit patterns under every delay code. A wrong delay length, a swapped lane or a missing pass-through path each produce mismatches at distinct bit positions. The capture strobe is driven with a 20-cycle train of nominal pulses with uneven spacing, with each predicted tap offset to match. This shows every capture code as its own shift of the train, so taps selected in the wrong order are exposed. Separate scenarios change the codes during a burst and immediately after it. These tell apart settings that are correctly held, settings loaded too early, and settings applied a cycle late. The cleared delay stages after reset are also checked.

// File: rtl/iot_timing_pkg.sv
package iot_timing_pkg;

    // Capture position codes; the encoding is decoded by software-facing logic
    typedef enum logic [1:0] {
        CAP_EARLY2  = 2'd0,
        CAP_EARLY1  = 2'd1,
        CAP_NOMINAL = 2'd2,
        CAP_LATE1   = 2'd3
    } cap_pos_e;

    // Positions in the predicted-strobe pipeline from the engine
    localparam int TAP_EARLY2  = 0;
    localparam int TAP_EARLY1  = 1;
    localparam int TAP_NOMINAL = 2;
    localparam int N_TAPS      = 3;

endpackage

// File: rtl/iot_cfg_hold.sv
module iot_cfg_hold
    import iot_timing_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_active,
    input  logic [SEL_W-1:0] in_code_i,
    input  logic [SEL_W-1:0] out_code_i,
    input  cap_pos_e         cap_code_i,
    output logic [SEL_W-1:0] in_sel_o,
    output logic [SEL_W-1:0] out_sel_o,
    output cap_pos_e         cap_sel_o
);

    typedef struct packed {
        logic [SEL_W-1:0] in_sel;
        logic [SEL_W-1:0] out_sel;
        cap_pos_e         cap_sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!burst_active) begin
            cfg_d.in_sel  = in_code_i;
            cfg_d.out_sel = out_code_i;
            cfg_d.cap_sel = cap_code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{in_sel: '0, out_sel: '0, cap_sel: CAP_EARLY2};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign in_sel_o  = cfg_q.in_sel;
    assign out_sel_o = cfg_q.out_sel;
    assign cap_sel_o = cfg_q.cap_sel;

    // R8: settings frozen across a burst
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |=> ($stable(in_sel_o) && $stable(out_sel_o) && $stable(cap_sel_o)));

    // R9: an idle edge loads the requested codes
    p_cfg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |=> (in_sel_o == $past(in_code_i)) && (cap_sel_o == $past(cap_code_i)));

endmodule

// File: rtl/iot_delay_line.sv
module iot_delay_line #(
    parameter int DEPTH = 3,
    parameter int SEL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);

    typedef struct packed {
        logic [DEPTH-1:0] stg;
    } dl_state_t;

    dl_state_t state_d, state_q;
    logic [DEPTH:0] taps;

    // Tap 0 is the undelayed input, tap k is k cycles old
    assign taps[0] = din;
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tap
        assign taps[gi+1] = state_q.stg[gi];
    end

    always_comb begin
        state_d        = state_q;
        state_d.stg[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            state_d.stg[i] = state_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dout = taps[sel];

endmodule

// File: rtl/iot_strobe_sel.sv
module iot_strobe_sel
    import iot_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TAPS-1:0] pre_strobe_i,
    input  cap_pos_e          sel_i,
    output logic              strobe_o
);

    typedef struct packed {
        logic late;
    } ss_state_t;

    ss_state_t state_d, state_q;

    always_comb begin
        state_d.late = pre_strobe_i[TAP_NOMINAL];
        unique case (sel_i)
            CAP_EARLY2:  strobe_o = pre_strobe_i[TAP_EARLY2];
            CAP_EARLY1:  strobe_o = pre_strobe_i[TAP_EARLY1];
            CAP_NOMINAL: strobe_o = pre_strobe_i[TAP_NOMINAL];
            default:     strobe_o = state_q.late;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R7: late capture trails the nominal tap by one cycle
    p_cap_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == CAP_LATE1 && $past(rst_n)) |-> (strobe_o == $past(pre_strobe_i[TAP_NOMINAL])));

endmodule

// File: rtl/spi_io_timing.sv
module spi_io_timing
    import iot_timing_pkg::*;
#(
    parameter int DLY_DEPTH = 3,
    localparam int SEL_W    = $clog2(DLY_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_active,
    input  logic [SEL_W-1:0]  in_dly_code,
    input  logic [SEL_W-1:0]  out_dly_code,
    input  logic [1:0]        cap_code,
    input  logic              miso_raw,
    input  logic              mosi_raw,
    input  logic [N_TAPS-1:0] pre_strobe,
    output logic              miso_dly,
    output logic              mosi_dly,
    output logic              cap_strobe
);

    logic [SEL_W-1:0] in_sel;
    logic [SEL_W-1:0] out_sel;
    cap_pos_e         cap_sel;

    iot_cfg_hold #(.SEL_W(SEL_W)) i_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_active (burst_active),
        .in_code_i    (in_dly_code),
        .out_code_i   (out_dly_code),
        .cap_code_i   (cap_pos_e'(cap_code)),
        .in_sel_o     (in_sel),
        .out_sel_o    (out_sel),
        .cap_sel_o    (cap_sel)
    );

    iot_delay_line #(.DEPTH(DLY_DEPTH), .SEL_W(SEL_W)) i_miso_dl (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (miso_raw),
        .sel   (in_sel),
        .dout  (miso_dly)
    );

    iot_delay_line #(.DEPTH(DLY_DEPTH), .SEL_W(SEL_W)) i_mosi_dl (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mosi_raw),
        .sel   (out_sel),
        .dout  (mosi_dly)
    );

    iot_strobe_sel i_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .pre_strobe_i (pre_strobe),
        .sel_i        (cap_sel),
        .strobe_o     (cap_strobe)
    );

    // R2: one-cycle input delay
    p_miso_dly1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sel == SEL_W'(1) && $past(rst_n)) |-> (miso_dly == $past(miso_raw)));

    // R3: one-cycle output delay
    p_mosi_dly1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == SEL_W'(1) && $past(rst_n)) |-> (mosi_dly == $past(mosi_raw)));

endmodule

// File: tb/test_spi_io_timing.sv
module test_spi_io_timing;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_active = 1'b0;
    logic [1:0] in_dly_code = '0;
    logic [1:0] out_dly_code = '0;
    logic [1:0] cap_code = '0;
    logic       miso_raw = 1'b0;
    logic       mosi_raw = 1'b0;
    logic [2:0] pre_strobe = '0;
    logic       miso_dly, mosi_dly, cap_strobe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [15:0] PAT_A = 16'hB2E5;
    localparam logic [15:0] PAT_B = 16'h4D9A;
    localparam logic [19:0] NOM   = 20'b0100_1100_0010_1000_1010;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_io_timing i_spi_io_timing (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_active (burst_active),
        .in_dly_code  (in_dly_code),
        .out_dly_code (out_dly_code),
        .cap_code     (cap_code),
        .miso_raw     (miso_raw),
        .mosi_raw     (mosi_raw),
        .pre_strobe   (pre_strobe),
        .miso_dly     (miso_dly),
        .mosi_dly     (mosi_dly),
        .cap_strobe   (cap_strobe)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic nom_at(int i);
        if (i < 0 || i > 19) return 1'b0;
        return NOM[i];
    endfunction

    task automatic flush();
        miso_raw = 1'b0; mosi_raw = 1'b0; pre_strobe = '0;
        repeat (4) tick();
    endtask

    // R1: reset state and cleared stages
    task automatic t_reset();
        rst_n = 1'b0; burst_active = 1'b0;
        in_dly_code = 2'd3; out_dly_code = 2'd3; cap_code = 2'd3;
        miso_raw = 1'b1; mosi_raw = 1'b1; pre_strobe = 3'b001;
        #1;
        chk("R1 miso passthrough in reset", miso_dly, 1'b1);
        chk("R1 mosi passthrough in reset", mosi_dly, 1'b1);
        chk("R1 capture code 0 in reset", cap_strobe, 1'b1);
        pre_strobe = 3'b100; #1;
        chk("R1 capture ignores nominal tap in reset", cap_strobe, 1'b0);
        pre_strobe = 3'b000;
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 miso cleared stage c1", miso_dly, 1'b0);
        chk("R1 mosi cleared stage c1", mosi_dly, 1'b0);
        tick();
        chk("R1 miso cleared stage c2", miso_dly, 1'b0);
        tick();
        chk("R1 miso first delayed bit", miso_dly, 1'b1);
        chk("R1 mosi first delayed bit", mosi_dly, 1'b1);
    endtask

    // R2 / R3: delay lanes with code n
    task automatic t_delay(int code);
        burst_active = 1'b0;
        in_dly_code = 2'(code); out_dly_code = 2'(code);
        flush();
        for (int k = 0; k < 16; k++) begin
            miso_raw = PAT_A[k]; mosi_raw = PAT_B[k];
            #1;
            chk($sformatf("R2 miso code %0d bit %0d", code, k), miso_dly,
                (k >= code) ? PAT_A[k-code] : 1'b0);
            chk($sformatf("R3 mosi code %0d bit %0d", code, k), mosi_dly,
                (k >= code) ? PAT_B[k-code] : 1'b0);
            tick();
        end
    endtask

    // R4..R7: capture position
    task automatic t_cap(int code);
        logic e;
        burst_active = 1'b0;
        cap_code = 2'(code);
        flush();
        for (int k = 0; k < 20; k++) begin
            pre_strobe = {nom_at(k), nom_at(k+1), nom_at(k+2)};
            #1;
            case (code)
                0: e = nom_at(k+2);
                1: e = nom_at(k+1);
                2: e = nom_at(k);
                default: e = nom_at(k-1);
            endcase
            case (code)
                0: chk($sformatf("R4 early2 cycle %0d", k), cap_strobe, e);
                1: chk($sformatf("R5 early1 cycle %0d", k), cap_strobe, e);
                2: chk($sformatf("R6 nominal cycle %0d", k), cap_strobe, e);
                default: chk($sformatf("R7 late1 cycle %0d", k), cap_strobe, e);
            endcase
            tick();
        end
    endtask

    // R8 / R9: settings held during a burst, loaded after it
    task automatic t_hold();
        burst_active = 1'b0;
        in_dly_code = 2'd0; out_dly_code = 2'd0; cap_code = 2'd0;
        flush();
        burst_active = 1'b1;
        in_dly_code = 2'd2; out_dly_code = 2'd2; cap_code = 2'd2;
        repeat (3) tick();
        miso_raw = 1'b1; mosi_raw = 1'b1; #1;
        chk("R8 miso still undelayed during burst", miso_dly, 1'b1);
        chk("R8 mosi still undelayed during burst", mosi_dly, 1'b1);
        pre_strobe = 3'b001; #1;
        chk("R8 capture still early2 during burst", cap_strobe, 1'b1);
        pre_strobe = 3'b100; #1;
        chk("R8 nominal tap unused during burst", cap_strobe, 1'b0);
        burst_active = 1'b0;
        miso_raw = 1'b0; mosi_raw = 1'b0; pre_strobe = 3'b000;
        tick();
        pre_strobe = 3'b100; #1;
        chk("R9 capture nominal after load", cap_strobe, 1'b1);
        pre_strobe = 3'b000;
        repeat (2) tick();
        miso_raw = 1'b1; #1;
        chk("R9 miso not passthrough after load", miso_dly, 1'b0);
        tick();
        miso_raw = 1'b0; #1;
        chk("R9 miso delay 2 c1", miso_dly, 1'b0);
        tick();
        chk("R9 miso delay 2 c2", miso_dly, 1'b1);
    endtask

    initial begin
        t_reset();
        for (int c = 0; c < 4; c++) t_delay(c);
        for (int c = 0; c < 4; c++) t_cap(c);
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule